// File: doc/BRIEF.md
# Serial Synthesizer Register Receiver

This block is the device side of a three-wire programming port for a PLL frequency synthesizer. A host drives a serial clock, a data line and a latch enable. The block shifts in words one bit per rising edge of the serial clock, with the most significant bit first. When latch enable rises, the block decodes the two lowest bits of the current 24-bit word. Those bits choose which of four internal latches receives the word.

The latched contents appear as parallel outputs:
- the reference divide ratio;
- the A and B counter values of the main divider;
- the 22-bit payloads of the function and initialization latches.

A reference word whose ratio is zero is rejected. It leaves the previous ratio in place and raises an error flag.

All three serial pins are brought into the system clock domain through a synchronizer of `SYNC_STAGES` flops. Edges of the serial clock and of latch enable are detected in that domain. The host must hold each serial level for at least `SYNC_STAGES + 1` system clock cycles.

Top module: `synth_prog_rx`

## Requirements
- R1: On each rising edge of `sclk_i`, the shift register takes `sdata_i` in at its least significant end, so bits arrive MSB first. When more than 24 bits are shifted before a latch, only the last 24 are used.
- R2: Latches update only on a rising edge of `le_i`. While `le_i` stays high, or when no rising edge occurs, all outputs keep their values, even if more bits are shifted in.
- R3: Word bits [1:0] pick the destination latch: 00 selects the reference latch, 01 the main divider latch, 10 the function latch and 11 the initialization latch.
- R4: A reference word with a nonzero value in bits [15:2] drives `ref_ratio_o` to that value. For example, word 0x000028 gives ratio 10.
- R5: A main divider word drives `a_cnt_o` from bits [7:2] and `b_cnt_o` from bits [20:8]. For example, word 0x004C49 gives A = 18 and B = 76.
- R6: A function word drives `func_word_o` from bits [23:2].
- R7: An initialization word drives both `init_word_o` and `func_word_o` from bits [23:2]. For example, word 0x8000C3 gives 0x200030 on both outputs.
- R8: A reference word with zero in bits [15:2] sets `ratio_err_o` and leaves `ref_ratio_o` unchanged. The next reference word with a nonzero ratio clears the flag. Words sent to other latches do not change the flag.
- R9: After reset, every output is zero and `ratio_err_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from host |
| sdata_i | input | 1 | Serial data, MSB first |
| le_i | input | 1 | Latch enable; rising edge transfers the word |
| ref_ratio_o | output | 14 | Reference divide ratio |
| a_cnt_o | output | 6 | A counter value |
| b_cnt_o | output | 13 | B counter value |
| func_word_o | output | 22 | Function latch payload |
| init_word_o | output | 22 | Initialization latch payload |
| ratio_err_o | output | 1 | Zero reference ratio was rejected |

## Verification
The assertions check, on every cycle, the following behaviours:
- outputs stay stable when no latch edge is detected;
- each decode path lands the shifted word's fields in the right output one cycle after the detected edge;
- a zero ratio raises the flag without touching the stored ratio;
- once a ratio is nonzero, it never returns to zero.

Only the bench's scenarios can show the serial behaviour:
- MSB-first ordering through the synchronizer;
- truncation to the last 24 bits after long bursts;
- the worked example words;
- outputs holding while bits keep arriving with latch enable held high.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int WORD_W = 24;
  localparam int SEL_W  = 2;
  localparam int REF_W  = 14;
  localparam int A_W    = 6;
  localparam int B_W    = 13;
  localparam int PAY_W  = WORD_W - SEL_W;
  localparam int A_LSB  = SEL_W;
  localparam int B_LSB  = A_LSB + A_W;

  typedef enum logic [SEL_W-1:0] {
    SEL_REF  = 2'b00,
    SEL_MAIN = 2'b01,
    SEL_FUNC = 2'b10,
    SEL_INIT = 2'b11
  } latch_sel_e;
endpackage

// File: rtl/synth_prog_sync.sv
module synth_prog_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/synth_prog_shift.sv
module synth_prog_shift
  import synth_prog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] word_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      word_o <= '0;
    end else begin
      sclk_q <= sclk_i;
      if (sclk_i && !sclk_q) word_o <= {word_o[WORD_W-2:0], sdata_i};
    end
  end
endmodule

// File: rtl/synth_prog_latches.sv
module synth_prog_latches
  import synth_prog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              le_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              le_rise_o,
  output logic [REF_W-1:0]  ref_ratio_o,
  output logic [A_W-1:0]    a_cnt_o,
  output logic [B_W-1:0]    b_cnt_o,
  output logic [PAY_W-1:0]  func_word_o,
  output logic [PAY_W-1:0]  init_word_o,
  output logic              ratio_err_o
);
  logic le_q;
  latch_sel_e sel;
  logic [REF_W-1:0] ratio_in;
  logic [PAY_W-1:0] payload;

  assign le_rise_o = le_i && !le_q;
  assign sel       = latch_sel_e'(word_i[SEL_W-1:0]);
  assign ratio_in  = word_i[SEL_W +: REF_W];
  assign payload   = word_i[WORD_W-1:SEL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      le_q        <= 1'b0;
      ref_ratio_o <= '0;
      a_cnt_o     <= '0;
      b_cnt_o     <= '0;
      func_word_o <= '0;
      init_word_o <= '0;
      ratio_err_o <= 1'b0;
    end else begin
      le_q <= le_i;
      if (le_rise_o) begin
        unique case (sel)
          SEL_REF: begin
            if (ratio_in == '0) begin
              ratio_err_o <= 1'b1;   // illegal ratio, keep old value
            end else begin
              ref_ratio_o <= ratio_in;
              ratio_err_o <= 1'b0;
            end
          end
          SEL_MAIN: begin
            a_cnt_o <= word_i[A_LSB +: A_W];
            b_cnt_o <= word_i[B_LSB +: B_W];
          end
          SEL_FUNC: func_word_o <= payload;
          SEL_INIT: begin
            init_word_o <= payload;
            func_word_o <= payload;  // init also loads function latch
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/synth_prog_rx.sv
module synth_prog_rx
  import synth_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             sdata_i,
  input  logic             le_i,
  output logic [REF_W-1:0] ref_ratio_o,
  output logic [A_W-1:0]   a_cnt_o,
  output logic [B_W-1:0]   b_cnt_o,
  output logic [PAY_W-1:0] func_word_o,
  output logic [PAY_W-1:0] init_word_o,
  output logic             ratio_err_o
);
  logic [2:0]        pins_s;
  logic [WORD_W-1:0] shift_word;
  logic              le_rise;

  synth_prog_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({le_i, sdata_i, sclk_i}),
    .q_o   (pins_s)
  );

  synth_prog_shift u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (pins_s[0]),
    .sdata_i(pins_s[1]),
    .word_o (shift_word)
  );

  synth_prog_latches u_latches (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .le_i       (pins_s[2]),
    .word_i     (shift_word),
    .le_rise_o  (le_rise),
    .ref_ratio_o(ref_ratio_o),
    .a_cnt_o    (a_cnt_o),
    .b_cnt_o    (b_cnt_o),
    .func_word_o(func_word_o),
    .init_word_o(init_word_o),
    .ratio_err_o(ratio_err_o)
  );
endmodule

// File: rtl/synth_prog_rx_chk.sv
module synth_prog_rx_chk
  import synth_prog_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              le_rise,
  input logic [WORD_W-1:0] shift_word,
  input logic [REF_W-1:0]  ref_ratio_o,
  input logic [A_W-1:0]    a_cnt_o,
  input logic [B_W-1:0]    b_cnt_o,
  input logic [PAY_W-1:0]  func_word_o,
  input logic [PAY_W-1:0]  init_word_o,
  input logic              ratio_err_o
);
  assert_hold_no_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !le_rise |=> ($stable(ref_ratio_o) && $stable(a_cnt_o) && $stable(b_cnt_o) &&
                  $stable(func_word_o) && $stable(init_word_o) && $stable(ratio_err_o)));

  assert_ref_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_rise && shift_word[1:0] == 2'b00 && shift_word[15:2] != '0) |=>
      (ref_ratio_o == $past(shift_word[15:2]) && !ratio_err_o));

  assert_main_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_rise && shift_word[1:0] == 2'b01) |=>
      (a_cnt_o == $past(shift_word[7:2]) && b_cnt_o == $past(shift_word[20:8])));

  assert_func_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_rise && shift_word[1:0] == 2'b10) |=>
      (func_word_o == $past(shift_word[23:2]) && $stable(init_word_o)));

  assert_init_mirror_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_rise && shift_word[1:0] == 2'b11) |=>
      (init_word_o == $past(shift_word[23:2]) && func_word_o == init_word_o));

  assert_zero_reject_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_rise && shift_word[1:0] == 2'b00 && shift_word[15:2] == '0) |=>
      (ratio_err_o && $stable(ref_ratio_o)));

  assert_ratio_never_zeroed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ref_ratio_o) != '0) |-> (ref_ratio_o != '0));
endmodule

bind synth_prog_rx synth_prog_rx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .le_rise    (le_rise),
  .shift_word (shift_word),
  .ref_ratio_o(ref_ratio_o),
  .a_cnt_o    (a_cnt_o),
  .b_cnt_o    (b_cnt_o),
  .func_word_o(func_word_o),
  .init_word_o(init_word_o),
  .ratio_err_o(ratio_err_o)
);

// File: tb/synth_prog_rx_tb.sv
module synth_prog_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, le = 1'b0;
  logic [13:0] ref_ratio;
  logic [5:0]  a_cnt;
  logic [12:0] b_cnt;
  logic [21:0] func_word, init_word;
  logic        ratio_err;

  int n_run = 0, n_fail = 0;
  logic [23:0] m_shift = '0;
  logic [13:0] e_ref = '0;
  logic [5:0]  e_a = '0;
  logic [12:0] e_b = '0;
  logic [21:0] e_func = '0, e_init = '0;
  logic        e_err = 1'b0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_prog_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .le_i(le),
    .ref_ratio_o(ref_ratio), .a_cnt_o(a_cnt), .b_cnt_o(b_cnt),
    .func_word_o(func_word), .init_word_o(init_word), .ratio_err_o(ratio_err)
  );

  task automatic chk(string req, string what, logic [23:0] act, logic [23:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(logic [31:0] bits, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = bits[i]; sclk = 1'b0; wait_clk(HOLD);
      sclk = 1'b1; wait_clk(HOLD);
      m_shift = {m_shift[22:0], bits[i]};
    end
    sclk = 1'b0; wait_clk(HOLD);
  endtask

  // reference model of one latch event (R3..R8)
  function automatic void model_latch(logic [23:0] w);
    case (w[1:0])
      2'b00: if (w[15:2] == 0) e_err = 1'b1; else begin e_ref = w[15:2]; e_err = 1'b0; end
      2'b01: begin e_a = w[7:2]; e_b = w[20:8]; end
      2'b10: e_func = w[23:2];
      default: begin e_init = w[23:2]; e_func = w[23:2]; end
    endcase
  endfunction

  task automatic pulse_le();
    le = 1'b1; wait_clk(HOLD + 2);
    model_latch(m_shift);
    le = 1'b0; wait_clk(HOLD);
  endtask

  task automatic check_all(string req);
    chk(req, "ref", 24'(ref_ratio), 24'(e_ref));
    chk(req, "a", 24'(a_cnt), 24'(e_a));
    chk(req, "b", 24'(b_cnt), 24'(e_b));
    chk(req, "func", 24'(func_word), 24'(e_func));
    chk(req, "init", 24'(init_word), 24'(e_init));
    chk(req, "err", 24'(ratio_err), 24'(e_err));
  endtask

  task automatic send(logic [23:0] w, string req);
    shift_bits({8'h0, w}, 24);
    pulse_le();
    check_all(req);
  endtask

  initial begin
    wait_clk(3);
    check_all("R9");
    rst_n = 1'b1;
    wait_clk(2);
    check_all("R9");

    send(24'h000028, "R4");
    chk("R4", "ratio10", 24'(ref_ratio), 24'd10);
    send(24'h004C49, "R5");
    chk("R5", "A18", 24'(a_cnt), 24'd18);
    chk("R5", "B76", 24'(b_cnt), 24'd76);
    send(24'h8000C3, "R7");
    chk("R7", "init", 24'(init_word), 24'h200030);
    chk("R7", "func", 24'(func_word), 24'h200030);
    send(24'h9B50A2, "R6");
    chk("R6", "func", 24'(func_word), 24'h26D428);
    chk("R6", "init_kept", 24'(init_word), 24'h200030);

    // R8: zero ratio rejected, then cleared by a valid one
    send(24'hFF0000, "R8");
    chk("R8", "flag", 24'(ratio_err), 24'd1);
    chk("R8", "kept", 24'(ref_ratio), 24'd10);
    send(24'h004B5D, "R8");
    chk("R8", "flag_kept_other", 24'(ratio_err), 24'd1);
    send(24'h110028, "R8");
    chk("R8", "flag_clear", 24'(ratio_err), 24'd0);

    // R1: 32 bits shifted, only the last 24 count
    shift_bits(32'hAB_00_01_2C, 32);
    pulse_le();
    check_all("R1");
    chk("R1", "ref75", 24'(ref_ratio), 24'd75);

    // R2: bits shifted while LE high and without LE edge have no effect
    le = 1'b1; wait_clk(HOLD + 2);
    model_latch(m_shift);
    shift_bits(32'h00_12_34_56, 24);
    check_all("R2");
    le = 1'b0; wait_clk(HOLD);
    shift_bits(32'h00_FF_FF_FD, 24);
    check_all("R2");
    pulse_le();
    check_all("R3");

    // random words, random extra prefix bits
    for (int k = 0; k < 40; k++) begin
      logic [31:0] r;
      int extra;
      r = $urandom;
      extra = $urandom_range(0, 8);
      shift_bits(r, 24 + extra);
      pulse_le();
      check_all("R3");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule